// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block keeps the reservation for one processor's atomic read-modify-write sequences. A load-linked request computes its effective address, records the word part of that address and arms a reservation flag. A later store-conditional request is allowed to commit only while that flag is still armed. The flag is dropped by a write from another master to the same word, which arrives on a snoop port, and by an exception-return strobe. A successful store-conditional also drops the flag.

Requests come in on a valid/ready port and each one produces exactly one response on a valid/ready port. The response carries the effective address, a commit strobe that permits the memory write, and the value to be written to the destination register. A load-linked returns its 32-bit loaded word sign-extended to register width. A store-conditional returns 1 when it succeeds and 0 when it fails, so software can retry with a branch-on-zero loop. Back-pressure: a request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high whenever the one-entry response stage is empty or is being drained in that cycle. A response that is presented and not taken stays unchanged until `rsp_ready` is high. Address translation, caches and memory are outside this block; the effective address is treated as the physical address.

Top module: `llsc_monitor`

## Requirements
- R1: The effective address is `req_base` plus `req_off` sign-extended from 16 bits, modulo 2^32. It is reported on `rsp_addr`.
- R2: A request with `req_op`=0 (load-linked) arms the reservation and records bits [31:2] of its effective address. Its response has `rsp_commit`=0 and `rsp_result` equal to `req_word` sign-extended to 64 bits.
- R3: A snoop cycle (`snp_valid`=1) clears the reservation when bits [31:2] of `snp_addr` equal the recorded word. The two low address bits are ignored. A snoop to any other word leaves the reservation armed.
- R4: A request with `req_op`=1 (store-conditional) taken while the reservation is armed responds with `rsp_commit`=1 and `rsp_result`=1, and it disarms the reservation.
- R5: A store-conditional taken while the reservation is not armed responds with `rsp_commit`=0 and `rsp_result`=0.
- R6: An `eret` pulse disarms the reservation. A store-conditional taken in the same cycle as `eret` fails.
- R7: A store-conditional taken in the same cycle as a snoop hit on the recorded word fails. A snoop to a different word in that cycle does not affect it.
- R8: Reset disarms the reservation, clears the recorded word and empties the response stage.
- R9: `req_ready` = !`rsp_valid` || `rsp_ready`. Each accepted request produces its response on the next cycle. A stalled response holds all of its fields.
- R10: A load-linked taken in the same cycle as `eret` or a snoop hit arms the reservation anyway.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_op | input | 1 | 0 = load-linked, 1 = store-conditional |
| req_base | input | 32 | Base register value |
| req_off | input | 16 | Signed address offset |
| req_word | input | 32 | Word loaded by a load-linked |
| snp_valid | input | 1 | Write by another master seen |
| snp_addr | input | 32 | Address of that write |
| eret | input | 1 | Exception-return strobe |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response can be taken |
| rsp_op | output | 1 | Operation of the response |
| rsp_addr | output | 32 | Effective address |
| rsp_commit | output | 1 | Store may be written to memory |
| rsp_result | output | 64 | Value for the destination register |

## Verification
On every cycle the assertions check the following: a snoop hit or an exception return leaves the reservation disarmed on the next cycle, a load-linked arms it with the recorded word, reset clears it, a same-cycle snoop hit forces a store-conditional to fail, only store-conditionals commit, and a stalled response holds steady. The bench's scenarios are needed for the rest. These cover the address arithmetic across sign and wrap boundaries, the sign extension of loaded words, and whether a snoop to a neighbouring word or to another byte of the same word changes a later outcome. They also cover the priority of a load-linked over a same-cycle clear and the full sequence of a retry after a lost reservation.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef enum logic {
    OP_LOAD_LINK  = 1'b0,
    OP_STORE_COND = 1'b1
  } llsc_op_e;

  localparam int unsigned WORD_LSB = 2;
endpackage

// File: rtl/llsc_agu.sv
module llsc_agu #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFF_W  = 16
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [OFF_W-1:0]  off,
  output logic [ADDR_W-1:0] eff
);
  localparam int unsigned EXT_W = ADDR_W - OFF_W;

  logic [ADDR_W-1:0] off_ext;

  always_comb begin
    off_ext = {{EXT_W{off[OFF_W-1]}}, off};
    eff     = base + off_ext;
  end
endmodule

// File: rtl/llsc_resv.sv
module llsc_resv #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LSB    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic [ADDR_W-1:0] arm_addr,
  input  logic              consume,
  input  logic              snp_valid,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic              eret,
  output logic              live,
  output logic              armed,
  output logic [ADDR_W-1:0] held_word
);
  logic              flag_q;
  logic [ADDR_W-1:0] word_q;
  logic              hit;

  always_comb begin
    hit   = snp_valid && ((snp_addr >> LSB) == word_q);
    live  = flag_q && !hit && !eret;
    armed = flag_q;
    held_word = word_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      word_q <= '0;
    end else if (arm) begin
      flag_q <= 1'b1;
      word_q <= arm_addr >> LSB;
    end else if (consume || hit || eret) begin
      flag_q <= 1'b0;
    end
  end

  p_ll_records_r2: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> flag_q && (word_q == ($past(arm_addr) >> LSB)));
  p_snoop_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && ((snp_addr >> LSB) == word_q) && !arm) |=> !flag_q);
  p_eret_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (eret && !arm) |=> !flag_q);
  p_reset_clears_r8: assert property (@(posedge clk)
    !rst_n |=> (!flag_q && word_q == '0));
endmodule

// File: rtl/llsc_resp.sv
module llsc_resp #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_fire,
  output logic              in_ready,
  input  logic              in_op,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic              in_commit,
  input  logic [DATA_W-1:0] in_result,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_op,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_commit,
  output logic [DATA_W-1:0] out_result
);
  logic              vld_q;
  logic              op_q;
  logic [ADDR_W-1:0] addr_q;
  logic              cmt_q;
  logic [DATA_W-1:0] res_q;

  always_comb begin
    in_ready   = !vld_q || out_ready;
    out_valid  = vld_q;
    out_op     = op_q;
    out_addr   = addr_q;
    out_commit = cmt_q;
    out_result = res_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      op_q   <= 1'b0;
      addr_q <= '0;
      cmt_q  <= 1'b0;
      res_q  <= '0;
    end else if (in_fire) begin
      vld_q  <= 1'b1;
      op_q   <= in_op;
      addr_q <= in_addr;
      cmt_q  <= in_commit;
      res_q  <= in_result;
    end else if (out_ready) begin
      vld_q  <= 1'b0;
    end
  end

  p_hold_stalled_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && !out_ready) |=> (vld_q && $stable(addr_q) && $stable(res_q)
                               && $stable(cmt_q) && $stable(op_q)));
  p_one_cycle_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire |=> vld_q);
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFF_W  = 16,
  parameter int unsigned WORD_W = 32,
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_op,
  input  logic [ADDR_W-1:0] req_base,
  input  logic [OFF_W-1:0]  req_off,
  input  logic [WORD_W-1:0] req_word,
  input  logic              snp_valid,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic              eret,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_op,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic              rsp_commit,
  output logic [DATA_W-1:0] rsp_result
);
  import llsc_pkg::*;

  localparam int unsigned SEXT_W = DATA_W - WORD_W;
  localparam int unsigned ZEXT_W = DATA_W - 1;

  logic              fire, do_ll, do_sc, live, armed, commit, ready_int;
  logic [ADDR_W-1:0] eff, held_word;
  logic [DATA_W-1:0] result;
  llsc_op_e          op;

  llsc_agu #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_agu (
    .base(req_base), .off(req_off), .eff(eff)
  );

  always_comb begin
    op     = llsc_op_e'(req_op);
    fire   = req_valid && ready_int;
    do_ll  = fire && (op == OP_LOAD_LINK);
    do_sc  = fire && (op == OP_STORE_COND);
    commit = do_sc && live;
    if (op == OP_LOAD_LINK) result = {{SEXT_W{req_word[WORD_W-1]}}, req_word};
    else                    result = {{ZEXT_W{1'b0}}, commit};
    req_ready = ready_int;
  end

  llsc_resv #(.ADDR_W(ADDR_W), .LSB(WORD_LSB)) u_resv (
    .clk(clk), .rst_n(rst_n),
    .arm(do_ll), .arm_addr(eff), .consume(do_sc),
    .snp_valid(snp_valid), .snp_addr(snp_addr), .eret(eret),
    .live(live), .armed(armed), .held_word(held_word)
  );

  llsc_resp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_resp (
    .clk(clk), .rst_n(rst_n),
    .in_fire(fire), .in_ready(ready_int),
    .in_op(req_op), .in_addr(eff), .in_commit(commit), .in_result(result),
    .out_valid(rsp_valid), .out_ready(rsp_ready), .out_op(rsp_op),
    .out_addr(rsp_addr), .out_commit(rsp_commit), .out_result(rsp_result)
  );

  p_sc_snoop_fail_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_op && snp_valid
     && ((snp_addr >> WORD_LSB) == held_word)) |=> !rsp_commit);
  p_sc_needs_armed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_op && !armed) |=> !rsp_commit);
  p_commit_only_sc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_commit) |-> rsp_op);
endmodule

// File: tb/tb_llsc_monitor.sv
module tb_llsc_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_op = 1'b0;
  logic [31:0] req_base = '0, req_word = '0, snp_addr = '0;
  logic [15:0] req_off = '0;
  logic        snp_valid = 1'b0, eret = 1'b0, rsp_ready = 1'b1;
  logic        req_ready, rsp_valid, rsp_op, rsp_commit;
  logic [31:0] rsp_addr;
  logic [63:0] rsp_result;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  logic        m_flag = 1'b0;
  logic [29:0] m_word = '0;

  llsc_monitor dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_base(req_base), .req_off(req_off), .req_word(req_word),
    .snp_valid(snp_valid), .snp_addr(snp_addr), .eret(eret),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_op(rsp_op),
    .rsp_addr(rsp_addr), .rsp_commit(rsp_commit), .rsp_result(rsp_result)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WATCHDOG) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog act=%0d exp<=%0d", cyc, WATCHDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp = n_cmp + 1;
    if (act !== exp) begin
      n_bad = n_bad + 1;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // One request plus optional same-cycle snoop/eret; response checked next cycle.
  task automatic issue(input string tag, input logic op, input logic [31:0] base,
                       input logic [15:0] off, input logic [31:0] word,
                       input logic sv, input logic [31:0] sa, input logic er);
    logic [31:0] ea;
    logic        hit, exp_c;
    logic [63:0] exp_r;
    ea  = base + {{16{off[15]}}, off};
    hit = sv && (sa[31:2] == m_word);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_base = base; req_off = off; req_word = word;
    snp_valid = sv; snp_addr = sa; eret = er;
    if (!op) begin
      exp_c = 1'b0; exp_r = {{32{word[31]}}, word};
      m_flag = 1'b1; m_word = ea[31:2];
    end else begin
      exp_c = m_flag && !hit && !er; exp_r = {63'b0, exp_c};
      m_flag = 1'b0;
    end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; snp_valid = 1'b0; eret = 1'b0;
    chk({tag, " R9 rsp_valid"}, {63'b0, rsp_valid}, 64'd1);
    chk({tag, " R1 addr"}, {32'b0, rsp_addr}, {32'b0, ea});
    chk({tag, " commit"}, {63'b0, rsp_commit}, {63'b0, exp_c});
    chk({tag, " result"}, rsp_result, exp_r);
  endtask

  task automatic side(input logic sv, input logic [31:0] sa, input logic er);
    @(negedge clk);
    snp_valid = sv; snp_addr = sa; eret = er;
    if (er || (sv && sa[31:2] == m_word)) m_flag = 1'b0;
    @(negedge clk);
    snp_valid = 1'b0; eret = 1'b0;
  endtask

  initial begin
    logic [31:0] bases [3];
    logic [15:0] offs [6];
    logic [31:0] ea, w;
    bases[0] = 32'h1000_0000; bases[1] = 32'hFFFF_FFF0; bases[2] = 32'h0000_8000;
    offs[0] = 16'h0000; offs[1] = 16'h0004; offs[2] = 16'hFFFC;
    offs[3] = 16'h7FFC; offs[4] = 16'h8000; offs[5] = 16'h0102;

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R8 rsp_valid after reset", {63'b0, rsp_valid}, 64'd0);
    rst_n = 1'b1;
    chk("R9 ready when empty", {63'b0, req_ready}, 64'd1);
    issue("R8 SC after reset", 1'b1, 32'h0, 16'h0, 32'h0, 1'b0, 32'h0, 1'b0);

    for (int b = 0; b < 3; b++) begin
      for (int o = 0; o < 6; o++) begin
        for (int v = 0; v < 8; v++) begin
          ea = bases[b] + {{16{offs[o][15]}}, offs[o]};
          w  = {(v[0] ? 8'h80 : 8'h7F), 8'(o), 8'(b), 8'(v)};
          issue("R2 LL", 1'b0, bases[b], offs[o], w, 1'b0, 32'h0, 1'b0);
          case (v)
            1: side(1'b1, ea, 1'b0);
            2: side(1'b1, ea ^ 32'h3, 1'b0);
            3: side(1'b1, ea + 32'h4, 1'b0);
            4: side(1'b0, 32'h0, 1'b1);
            default: ;
          endcase
          if (v == 5)
            issue("R7 SC snoop hit same cycle", 1'b1, bases[b], offs[o], 32'h0, 1'b1, ea, 1'b0);
          else if (v == 6)
            issue("R7 SC snoop miss same cycle", 1'b1, bases[b], offs[o], 32'h0, 1'b1, ea - 32'h4, 1'b0);
          else if (v == 7) begin
            issue("R10 LL with eret and snoop", 1'b0, bases[b], offs[o], w, 1'b1, ea, 1'b1);
            issue("R10 SC after LL win", 1'b1, bases[b], offs[o], 32'h0, 1'b0, 32'h0, 1'b0);
          end else
            issue((v == 4) ? "R6 SC after eret" : (v == 0) ? "R4 SC armed" : "R3 SC after snoop",
                  1'b1, bases[b], offs[o], 32'h0, 1'b0, 32'h0, 1'b0);
          issue("R5 SC second", 1'b1, bases[b], offs[o], 32'h0, 1'b0, 32'h0, 1'b0);
        end
      end
    end

    issue("R2 LL", 1'b0, 32'h3000, 16'h0, 32'h1, 1'b0, 32'h0, 1'b0);
    issue("R6 SC with eret same cycle", 1'b1, 32'h3000, 16'h0, 32'h0, 1'b0, 32'h0, 1'b1);

    // Back-pressure
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_op = 1'b0; req_base = 32'h2000; req_off = 16'h0; req_word = 32'h5;
    @(posedge clk);
    @(negedge clk);
    req_op = 1'b1;
    chk("R9 ready low when stalled", {63'b0, req_ready}, 64'd0);
    chk("R9 stalled addr", {32'b0, rsp_addr}, 64'h2000);
    @(negedge clk);
    chk("R9 still valid", {63'b0, rsp_valid}, 64'd1);
    chk("R9 stalled result", rsp_result, 64'h5);
    chk("R9 stalled op", {63'b0, rsp_op}, 64'd0);
    rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 SC after drain op", {63'b0, rsp_op}, 64'd1);
    chk("R4 SC after drain commit", {63'b0, rsp_commit}, 64'd1);
    m_flag = 1'b0;

    // Reset in the middle of a reservation
    issue("R2 LL", 1'b0, 32'h4000, 16'h0, 32'h9, 1'b0, 32'h0, 1'b0);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1; m_flag = 1'b0; m_word = '0;
    chk("R8 rsp_valid cleared", {63'b0, rsp_valid}, 64'd0);
    issue("R8 SC after mid reset", 1'b1, 32'h4000, 16'h0, 32'h0, 1'b0, 32'h0, 1'b0);

    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule